// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that sits in ordinary memory. The upper ten bits of the virtual address index a top-level table, whose location is given by a base-address input. The entry read there points to a second-level table. The next ten bits index that second-level table, and the entry read there supplies the physical frame number. The low twelve bits pass through as the byte offset within the frame.

A walk starts with a valid/ready request carrying the address and a read/write flag. The walker then reads one word per level from a simple synchronous memory port, where read data returns one cycle after the read strobe. At each level it checks the present bit and the write-permit bit. When the walk succeeds, it writes the final entry back with the referenced bit set, and with the dirty bit also set for a write, before it answers. The answer is either a physical address or a fault with a cause code. Only one walk is in flight at a time, and a busy output shows that a walk is in progress.

Entry format, identical at both levels: frame number in bits [31:12], cache-disable in bit 4, dirty in bit 3, referenced in bit 2, write-permit in bit 1, present in bit 0.

Top module: `pt_walker`

## Requirements
- R1: After a request is accepted, the first memory read goes to `ptBase + 4*va[31:22]`.
- R2: When the top-level entry is usable, the second memory read goes to `{outerEntry[31:12], 12'h000} + 4*va[21:12]`.
- R3: On a successful walk, `rspPaddr = {innerEntry[31:12], va[11:0]}` and `rspNoCache = innerEntry[4]`. On any fault both are 0.
- R4: A top-level entry with bit 0 clear ends the walk with cause 1 (outer not present). No second read and no memory write take place.
- R5: A second-level entry with bit 0 clear ends the walk with cause 2 (inner not present), with no memory write.
- R6: A write request meets an entry whose bit 1 is clear at either level ends with cause 3 (protection), and nothing is written back. At each level the present check wins over the protection check. The top level is judged before the second level.
- R7: A successful walk performs exactly one memory write, to the second-level entry address. The value written is the entry with bit 2 set, with bit 3 also set for a write, and every other bit unchanged. The write completes before the response is shown. Cause is then 0.
- R8: `reqReady` is high only while no walk is in progress. Once `rspValid` is high, it stays high with stable cause and address until `rspReady` is seen.
- R9: `busy` is high from the cycle after a request is accepted until the response is consumed.
- R10: After reset the walker is idle: `reqReady=1`, and `rspValid`, `busy`, `memRead` and `memWrite` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptBase | input | 32 | Byte address of the top-level table, sampled when a request is accepted |
| reqValid | input | 1 | Walk request present |
| reqReady | output | 1 | Walker can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rspValid | output | 1 | Result available |
| rspReady | input | 1 | Consumer takes the result |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspNoCache | output | 1 | Cache-disable bit of the final entry (0 on fault) |
| rspCause | output | 2 | 0 ok, 1 outer not present, 2 inner not present, 3 protection |
| busy | output | 1 | A walk is in progress |
| memRead | output | 1 | Word read strobe; data is returned on memRdata in the next cycle |
| memWrite | output | 1 | Word write strobe |
| memAddr | output | 32 | Byte address of the memory access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after memRead |

## Verification
Several properties are checked on every clock. A read and a write are never issued together. A held response keeps its value. Every write-back carries the present and referenced bits, and carries the dirty bit for a write access. A successful response always keeps the virtual offset in its low bits. Only the bench's scenarios can show the other behaviours. These are the exact read addresses at each level, the choice between fault causes and their precedence, and the absence of a second read or a write-back after a fault. The bench sweeps every second-level index under two top-level entries with differing permissions, for both access types. Each result is compared with an arithmetic model built over the bench's own memory image.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Entry bit positions (both table levels share one layout)
  localparam int PTE_PRESENT = 0;
  localparam int PTE_WRITABLE = 1;
  localparam int PTE_REFERENCED = 2;
  localparam int PTE_DIRTY = 3;
  localparam int PTE_NOCACHE = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_OUTER_NP = 2'd1,
    CAUSE_INNER_NP = 2'd2,
    CAUSE_PROT     = 2'd3
  } faultCause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_UPDATE,
    ST_RESP
  } walkState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic selOuter;
    logic loadOuter;
    logic loadInner;
  } walkStrobes_t;

endpackage

// File: rtl/pt_walker_datapath.sv
module pt_walker_datapath
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [ADDR_W-1:0] memRdata,
  input  logic              rspOk,
  input  logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic              rdPresent,
  output logic              rdWritable,
  output logic              walkWrite,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspNoCache
);

  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int ENTRY_BYTES_LOG2 = 2;

  logic [ADDR_W-1:0] vaReg;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] pteOuter;
  logic [ADDR_W-1:0] pteInner;
  logic              wrReg;

  logic [IDX_W-1:0]  outerIdx;
  logic [IDX_W-1:0]  innerIdx;
  logic [ADDR_W-1:0] outerAddr;
  logic [ADDR_W-1:0] innerAddr;
  logic [ADDR_W-1:0] updMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      pteOuter <= '0;
      pteInner <= '0;
      wrReg    <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        vaReg   <= reqVaddr;
        baseReg <= ptBase;
        wrReg   <= reqWrite;
      end
      if (strb.loadOuter) pteOuter <= memRdata;
      if (strb.loadInner) pteInner <= memRdata;
    end
  end

  assign outerIdx = vaReg[ADDR_W-1 -: IDX_W];
  assign innerIdx = vaReg[OFF_W +: IDX_W];

  assign outerAddr = baseReg + ADDR_W'({outerIdx, {ENTRY_BYTES_LOG2{1'b0}}});
  assign innerAddr = {pteOuter[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                   + ADDR_W'({innerIdx, {ENTRY_BYTES_LOG2{1'b0}}});

  assign memAddr = strb.selOuter ? outerAddr : innerAddr;

  always_comb begin
    updMask = '0;
    updMask[PTE_REFERENCED] = 1'b1;
    updMask[PTE_DIRTY] = wrReg;
  end

  assign memWdata   = pteInner | updMask;
  assign rdPresent  = memRdata[PTE_PRESENT];
  assign rdWritable = memRdata[PTE_WRITABLE];
  assign walkWrite  = wrReg;

  assign rspPaddr   = rspOk ? {pteInner[ADDR_W-1 -: FRAME_W], vaReg[OFF_W-1:0]} : '0;
  assign rspNoCache = rspOk & pteInner[PTE_NOCACHE];

  // R7: write-back always marks the entry referenced and keeps it present
  p_wb_ref_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memWdata[PTE_REFERENCED] && memWdata[PTE_PRESENT]));

  // R7: a write access sets dirty on write-back
  p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && walkWrite) |-> memWdata[PTE_DIRTY]);

  // R3: a successful translation keeps the virtual page offset
  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspOk |-> (rspPaddr[OFF_W-1:0] == vaReg[OFF_W-1:0]));

  // R2: second-level addresses are word aligned
  p_inner_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.selOuter && memWrite) |-> (memAddr[ENTRY_BYTES_LOG2-1:0] == '0));

endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         rspValid,
  input  logic         rspReady,
  output logic [1:0]   rspCause,
  output logic         rspOk,
  output logic         busy,
  output logic         memRead,
  output logic         memWrite,
  input  logic         rdPresent,
  input  logic         rdWritable,
  input  logic         walkWrite,
  output walkStrobes_t strb
);

  walkState_e  state, stateNext;
  faultCause_e cause, causeNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cause <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      cause <= causeNext;
    end
  end

  always_comb begin
    stateNext = state;
    causeNext = cause;
    strb      = '0;
    memRead   = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          causeNext    = CAUSE_NONE;
          stateNext    = ST_RD_OUTER;
        end
      end
      ST_RD_OUTER: begin
        strb.selOuter = 1'b1;
        memRead       = 1'b1;
        stateNext     = ST_WT_OUTER;
      end
      ST_WT_OUTER: begin
        strb.loadOuter = 1'b1;
        if (!rdPresent) begin
          causeNext = CAUSE_OUTER_NP;
          stateNext = ST_RESP;
        end else if (walkWrite && !rdWritable) begin
          causeNext = CAUSE_PROT;
          stateNext = ST_RESP;
        end else begin
          stateNext = ST_RD_INNER;
        end
      end
      ST_RD_INNER: begin
        memRead   = 1'b1;
        stateNext = ST_WT_INNER;
      end
      ST_WT_INNER: begin
        strb.loadInner = 1'b1;
        if (!rdPresent) begin
          causeNext = CAUSE_INNER_NP;
          stateNext = ST_RESP;
        end else if (walkWrite && !rdWritable) begin
          causeNext = CAUSE_PROT;
          stateNext = ST_RESP;
        end else begin
          stateNext = ST_UPDATE;
        end
      end
      ST_UPDATE: begin
        memWrite  = 1'b1;
        stateNext = ST_RESP;
      end
      ST_RESP: begin
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign rspCause = cause;
  assign rspOk    = rspValid && (cause == CAUSE_NONE);
  assign busy     = (state != ST_IDLE);

  // R7: the memory port never carries a read and a write together
  p_mem_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  // R7: a write-back is followed by a fault-free response
  p_wb_then_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |=> (rspValid && rspCause == CAUSE_NONE));

  // R8: a pending response is held until consumed
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspCause)));

  // R9: an accepted request makes the walker busy
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !reqReady));

  // R4: an outer fault is never followed by a memory access
  p_no_access_after_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCause == CAUSE_OUTER_NP) |-> (!memRead && !memWrite));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspNoCache,
  output logic [1:0]        rspCause,
  output logic              busy,
  output logic              memRead,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata
);

  walkStrobes_t strb;
  logic rdPresent;
  logic rdWritable;
  logic walkWrite;
  logic rspOk;

  pt_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .rspReady   (rspReady),
    .rspCause   (rspCause),
    .rspOk      (rspOk),
    .busy       (busy),
    .memRead    (memRead),
    .memWrite   (memWrite),
    .rdPresent  (rdPresent),
    .rdWritable (rdWritable),
    .walkWrite  (walkWrite),
    .strb       (strb)
  );

  pt_walker_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .ptBase     (ptBase),
    .memRdata   (memRdata),
    .rspOk      (rspOk),
    .memWrite   (memWrite),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .rdPresent  (rdPresent),
    .rdWritable (rdWritable),
    .walkWrite  (walkWrite),
    .rspPaddr   (rspPaddr),
    .rspNoCache (rspNoCache)
  );

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ptBase = 32'h0000_3000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [31:0] rspPaddr;
  logic        rspNoCache;
  logic [1:0]  rspCause;
  logic        busy;
  logic        memRead;
  logic        memWrite;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rstN(rstN), .ptBase(ptBase),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspNoCache(rspNoCache), .rspCause(rspCause), .busy(busy),
    .memRead(memRead), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Bench memory: 16 KB, one-cycle read latency
  logic [31:0] mem [0:4095];
  logic [31:0] rdLog [0:7];
  logic [31:0] wrLog [0:7];
  int rdCnt = 0;
  int wrCnt = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRead) begin
      memRdata <= mem[memAddr[13:2]];
      rdLog[rdCnt[2:0]] <= memAddr;
      rdCnt <= rdCnt + 1;
    end
    if (memWrite) begin
      mem[memAddr[13:2]] <= memWdata;
      wrLog[wrCnt[2:0]] <= memAddr;
      wrCnt <= wrCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] innerEntry(input int tbl, input int i);
    logic [31:0] e;
    if (tbl == 1) begin
      e = 32'(32'h400 + i) << 12;
      e[4] = (i % 5 == 0);
      e[1] = (i % 2 == 1);
      e[0] = (i % 3 != 0);
    end else begin
      e = (32'(32'h800 + i) << 12) | 32'h3;
    end
    return e;
  endfunction

  task automatic initMem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    for (int i = 0; i < 1024; i++) begin
      mem[1024 + i] = innerEntry(1, i);
      mem[2048 + i] = innerEntry(2, i);
    end
    mem[3072 + 5]    = 32'h0000_1003;  // frame 1, present, writable
    mem[3072 + 700]  = 32'h0000_2001;  // frame 2, present, read-only
    mem[3072 + 1023] = 32'h0000_1013;  // frame 1, writable, nocache at outer
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input int holdOff);
    logic [31:0] oAddr, o, iAddr, e, expPa, expNew;
    logic [1:0]  expCause;
    bit          expNc;
    int          expRd, expWr, r0, w0, wait_n;
    logic [31:0] capPa;
    logic [1:0]  capCause;
    // model
    oAddr = ptBase + {20'd0, va[31:22], 2'b00};
    o = mem[oAddr[13:2]];
    iAddr = {o[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    e = mem[iAddr[13:2]];
    expPa = 0; expNc = 0; expNew = e; expWr = 0; expRd = 2;
    if (!o[0]) begin expCause = 2'd1; expRd = 1; end
    else if (wr && !o[1]) begin expCause = 2'd3; expRd = 1; end
    else if (!e[0]) expCause = 2'd2;
    else if (wr && !e[1]) expCause = 2'd3;
    else begin
      expCause = 2'd0; expWr = 1;
      expPa = {e[31:12], va[11:0]}; expNc = e[4];
      expNew = e | 32'h4 | (wr ? 32'h8 : 32'h0);
    end
    r0 = rdCnt; w0 = wrCnt;
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqValid = 1'b1; rspReady = (holdOff == 0);
    check(reqReady == 1'b1, "R8 ready when idle", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy && !reqReady, "R9 busy after accept", {30'd0, busy, reqReady}, 32'd2);
    wait_n = 0;
    while (!rspValid && wait_n < 50) begin
      check(busy == 1'b1, "R9 busy during walk", {31'd0, busy}, 32'd1);
      @(negedge clk); wait_n++;
    end
    check(rspValid == 1'b1, "R8 response arrives", {31'd0, rspValid}, 32'd1);
    capPa = rspPaddr; capCause = rspCause;
    for (int k = 0; k < holdOff; k++) begin
      @(negedge clk);
      check(rspValid && rspPaddr == capPa && rspCause == capCause,
            "R8 response held", rspPaddr, capPa);
      check(busy == 1'b1, "R9 busy while held", {31'd0, busy}, 32'd1);
    end
    check(rspCause == expCause, "R4 R5 R6 R7 cause", {30'd0, rspCause}, {30'd0, expCause});
    check(rspPaddr == expPa, "R3 physical address", rspPaddr, expPa);
    check(rspNoCache == expNc, "R3 cache-disable", {31'd0, rspNoCache}, {31'd0, expNc});
    check(rdCnt - r0 == expRd, "R4 read count", 32'(rdCnt - r0), 32'(expRd));
    check(wrCnt - w0 == expWr, "R6 R7 write count", 32'(wrCnt - w0), 32'(expWr));
    check(rdLog[r0[2:0]] == oAddr, "R1 outer read address", rdLog[r0[2:0]], oAddr);
    if (expRd == 2)
      check(rdLog[3'(r0 + 1)] == iAddr, "R2 inner read address", rdLog[3'(r0 + 1)], iAddr);
    if (expWr == 1)
      check(wrLog[w0[2:0]] == iAddr, "R7 write-back address", wrLog[w0[2:0]], iAddr);
    check(mem[iAddr[13:2]] == expNew, "R6 R7 entry after walk", mem[iAddr[13:2]], expNew);
    rspReady = 1'b1;
    @(negedge clk);
    check(!rspValid && !busy && reqReady, "R9 idle after consume",
          {29'd0, rspValid, busy, reqReady}, 32'd1);
  endtask

  initial begin
    initMem();
    repeat (3) @(negedge clk);
    check(reqReady && !rspValid && !busy && !memRead && !memWrite, "R10 reset state",
          {27'd0, reqReady, rspValid, busy, memRead, memWrite}, 32'h10);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && !busy && !memRead && !memWrite, "R10 idle after reset",
          {27'd0, reqReady, rspValid, busy, memRead, memWrite}, 32'h10);
    // Outer not present (R4)
    walk(32'h0000_0ABC, 1'b0, 0);
    walk(32'h00C0_1234, 1'b1, 0);
    // Full sweep under a writable outer entry, both access types (R3 R5 R6 R7)
    for (int i = 0; i < 1024; i++) begin
      walk({10'd5, 10'(i), 12'(i * 7)}, 1'b0, 0);
      walk({10'd5, 10'(i), 12'(4095 - i)}, 1'b1, 0);
    end
    // Read-only outer entry: reads succeed, writes fault at the top level (R6)
    for (int i = 0; i < 1024; i++) begin
      walk({10'd700, 10'(i), 12'(i)}, 1'b0, 0);
      walk({10'd700, 10'(i), 12'(i)}, 1'b1, 0);
    end
    // Last outer index, with response backpressure (R8)
    walk({10'd1023, 10'd1, 12'hFFF}, 1'b1, 4);
    walk({10'd1023, 10'd3, 12'h000}, 1'b1, 3);
    walk({10'd1023, 10'd0, 12'h555}, 1'b0, 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule